// File: doc/BRIEF.md
# Multiplexed Asynchronous External Memory Bridge

This block connects an internal single-word request port to an external bus for asynchronous SRAM or EEPROM. Address and data share one 16-bit bus. An address phase with a latch-enable pulse comes first, then a data phase. In the data phase a read or write strobe is held low for a fixed number of clocks, and one idle clock closes the cycle. Four fixed address windows are decoded. Each window has its own active-low select and its own setting for a 16-bit or an 8-bit device.

For 16-bit windows the bus carries the word address, and two byte enables allow partial writes. For 8-bit windows each request becomes two byte cycles, low byte first. The seventeenth address line gives access to the full 128 kB. A global enable input gates the whole port. A request that misses every window, or that arrives while the port is disabled, never reaches the pins and completes with an error.

Top module: `muxMemBridge`

## Requirements
- R1: While reset is held, every memory select, the read strobe and the write strobe are high, the latch enable and the response valid are low, and the request port reports ready.
- R2: With the global enable low, an accepted request drives no select and answers one clock later with the error flag set and read data of zero.
- R3: Window n (0..3) is hit when address bits [31:28] equal n+1 and bits [27:17] are zero, and it drives select bit n low. Any other address gets the error response of R2 and drives no select.
- R4: A forwarded byte or word cycle runs as follows: one address clock with the latch enable high, then STROBE_CLKS clocks with one strobe low, then one idle clock. The response valid comes in the idle clock of the last cycle, 2+STROBE_CLKS clocks after acceptance for a 16-bit window, and a write returns read data of zero.
- R5: In a 16-bit window the address phase drives request address bits [16:1] on the bus, and the extra address line stays low.
- R6: In a 16-bit window a write drives the low-byte enable low when request byte-enable bit 0 is set, and the high-byte enable low when bit 1 is set. A read drives both low.
- R7: During the data phase of a read the bridge releases the bus (output enable low). Read data is sampled at the edge that ends the last strobe clock.
- R8: In an 8-bit window a request becomes two byte cycles at byte addresses {addr[16:1],0} and then {addr[16:1],1}. The bus carries bits [15:0] of that byte address and the extra line carries bit 16. Data travels on bus bits [7:0], low byte first. Only the low-byte enable is driven low. The response comes 2*(2+STROBE_CLKS) clocks after acceptance.
- R9: At most one select is low at a time, and the read and write strobes are never low together.
- R10: The request port reports ready only when the bridge is idle, so no request is taken while a cycle is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portEnable | input | 1 | Global enable of the external port |
| regionIs8Bit | input | 4 | Per-window device width, 1 = 8-bit device |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Bridge idle, request accepted on this clock |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Request byte address |
| reqWdata | input | 16 | Write data |
| reqByteEn | input | 2 | Write byte enables, bit 0 = low byte |
| respValid | output | 1 | One-clock completion pulse |
| respError | output | 1 | Request was not forwarded |
| respRdata | output | 16 | Read data |
| adOut | output | 16 | Value driven onto the shared address/data bus |
| adOe | output | 1 | Bus output enable, 0 = released |
| adIn | input | 16 | Value read from the shared bus |
| a16 | output | 1 | Extra address line for 8-bit devices |
| memSelN | output | 4 | Active-low window selects |
| latchEn | output | 1 | Address latch enable |
| readN | output | 1 | Active-low read strobe |
| writeN | output | 1 | Active-low write strobe |
| byteHighN | output | 1 | Active-low high-byte enable |
| byteLowN | output | 1 | Active-low low-byte enable |

## Verification
The hardest case to reach is the second byte cycle of an 8-bit window when bit 16 of the address is set and the byte address crosses into the top of the window. That cycle only happens after the control re-enters the address phase from the idle clock, and a wrong extra address line or a wrong byte order would still give correct data on a device that had been written the same wrong way. The stimulus therefore uses a pin-level device model that latches every address phase with its select and extra address line. The bench compares those latched entries with the expected byte addresses, using windows placed at 0x20010200 and 0x4001FFFE. Read-back data comes from a shadow copy kept by the driver, never from the device itself.

// File: rtl/muxMemPkg.sv
package muxMemPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_GAP,
    ST_ERR
  } ctrlState_e;

  // Strobes from the control FSM into the datapath
  typedef struct packed {
    logic load;       // latch request fields
    logic addrPhase;  // address on the bus
    logic dataPhase;  // strobe clocks
    logic capture;    // sample read data
    logic upperByte;  // second byte cycle of an 8-bit window
    logic wide8;      // current window is 8-bit
    logic isWrite;
    logic errResp;    // response is an error
  } dpStrobe_t;
endpackage

// File: rtl/muxMemCtrl.sv
module muxMemCtrl
  import muxMemPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 4,
  parameter int STROBE_CLKS = 3,
  parameter int WIN_BITS    = 17
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   portEnable,
  input  logic [NUM_REGIONS-1:0] regionIs8Bit,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [ADDR_W-1:0]      reqAddr,
  output logic                   reqReady,
  output logic                   respValid,
  output logic                   respError,
  output logic [NUM_REGIONS-1:0] memSelN,
  output logic                   latchEn,
  output logic                   readN,
  output logic                   writeN,
  output logic                   adOe,
  output dpStrobe_t              strobe
);
  localparam int REG_LSB = ADDR_W - 4;
  localparam int CNT_W   = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);

  ctrlState_e state;
  logic [CNT_W-1:0]       cnt;
  logic [NUM_REGIONS-1:0] hitVec, selQ;
  logic                   wide8Q, isWriteQ, upperQ;
  logic                   accept, anyHit, lastByte;

  // Window decode: top nibble picks the window, middle bits must be zero
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gDecode
    assign hitVec[g] = (reqAddr[ADDR_W-1:REG_LSB] == 4'(g + 1)) &&
                       (reqAddr[REG_LSB-1:WIN_BITS] == '0);
  end

  assign anyHit   = |hitVec;
  assign accept   = reqValid && (state == ST_IDLE);
  assign lastByte = !wide8Q || upperQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      selQ     <= '0;
      wide8Q   <= 1'b0;
      isWriteQ <= 1'b0;
      upperQ   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          if (portEnable && anyHit) begin
            state    <= ST_ADDR;
            selQ     <= hitVec;
            wide8Q   <= |(hitVec & regionIs8Bit);
            isWriteQ <= reqWrite;
            upperQ   <= 1'b0;
          end else begin
            state <= ST_ERR;
          end
        end
        ST_ADDR: begin
          state <= ST_DATA;
          cnt   <= '0;
        end
        ST_DATA: begin
          if (cnt == CNT_LAST) state <= ST_GAP;
          else                 cnt   <= cnt + 1'b1;
        end
        ST_GAP: begin
          if (lastByte) begin
            state <= ST_IDLE;
          end else begin
            upperQ <= 1'b1;
            state  <= ST_ADDR;
          end
        end
        ST_ERR:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady  = (state == ST_IDLE);
    latchEn   = (state == ST_ADDR);
    memSelN   = (state == ST_ADDR || state == ST_DATA) ? ~selQ : '1;
    readN     = !(state == ST_DATA && !isWriteQ);
    writeN    = !(state == ST_DATA && isWriteQ);
    adOe      = (state == ST_ADDR) || (state == ST_DATA && isWriteQ);
    respValid = (state == ST_ERR) || (state == ST_GAP && lastByte);
    respError = (state == ST_ERR);

    strobe.load      = accept;
    strobe.addrPhase = (state == ST_ADDR);
    strobe.dataPhase = (state == ST_DATA);
    strobe.capture   = (state == ST_DATA) && (cnt == CNT_LAST) && !isWriteQ;
    strobe.upperByte = upperQ;
    strobe.wide8     = wide8Q;
    strobe.isWrite   = isWriteQ;
    strobe.errResp   = (state == ST_ERR);
  end
endmodule

// File: rtl/muxMemDatapath.sv
module muxMemDatapath
  import muxMemPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqByteEn,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              a16,
  output logic              byteHighN,
  output logic              byteLowN,
  output logic [DATA_W-1:0] respRdata
);
  localparam int WIN_BITS = DATA_W + 1;
  localparam int BYTE_W   = DATA_W / 2;

  logic [WIN_BITS-1:0] addrQ, byteAddr;
  logic [DATA_W-1:0]   wdataQ, rdataQ;
  logic [1:0]          beQ;
  logic [BYTE_W-1:0]   wByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      rdataQ <= '0;
    end else if (strobe.load) begin
      addrQ  <= reqAddr[WIN_BITS-1:0];
      wdataQ <= reqWdata;
      beQ    <= reqByteEn;
      rdataQ <= '0;
    end else if (strobe.capture) begin
      if (!strobe.wide8)        rdataQ                <= adIn;
      else if (strobe.upperByte) rdataQ[DATA_W-1:BYTE_W] <= adIn[BYTE_W-1:0];
      else                       rdataQ[BYTE_W-1:0]      <= adIn[BYTE_W-1:0];
    end
  end

  // Byte address of the current byte cycle in an 8-bit window
  assign byteAddr = {addrQ[WIN_BITS-1:1], strobe.upperByte};
  assign wByte    = strobe.upperByte ? wdataQ[DATA_W-1:BYTE_W] : wdataQ[BYTE_W-1:0];

  always_comb begin
    adOut = '0;
    if (strobe.addrPhase)
      adOut = strobe.wide8 ? byteAddr[DATA_W-1:0] : addrQ[WIN_BITS-1:1];
    else if (strobe.dataPhase)
      adOut = strobe.wide8 ? {{BYTE_W{1'b0}}, wByte} : wdataQ;
  end

  assign a16       = (strobe.addrPhase || strobe.dataPhase) && strobe.wide8 &&
                     byteAddr[WIN_BITS-1];
  assign byteLowN  = !(strobe.dataPhase &&
                       (strobe.wide8 || !strobe.isWrite || beQ[0]));
  assign byteHighN = !(strobe.dataPhase && !strobe.wide8 &&
                       (!strobe.isWrite || beQ[1]));
  assign respRdata = strobe.errResp ? '0 : rdataQ;
endmodule

// File: rtl/muxMemBridge.sv
module muxMemBridge
  import muxMemPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 16,
  parameter int NUM_REGIONS = 4,
  parameter int STROBE_CLKS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   portEnable,
  input  logic [NUM_REGIONS-1:0] regionIs8Bit,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [1:0]             reqByteEn,
  output logic                   respValid,
  output logic                   respError,
  output logic [DATA_W-1:0]      respRdata,
  output logic [DATA_W-1:0]      adOut,
  output logic                   adOe,
  input  logic [DATA_W-1:0]      adIn,
  output logic                   a16,
  output logic [NUM_REGIONS-1:0] memSelN,
  output logic                   latchEn,
  output logic                   readN,
  output logic                   writeN,
  output logic                   byteHighN,
  output logic                   byteLowN
);
  dpStrobe_t strobe;

  muxMemCtrl #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS),
    .STROBE_CLKS(STROBE_CLKS), .WIN_BITS(DATA_W + 1)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .portEnable(portEnable),
    .regionIs8Bit(regionIs8Bit), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqReady(reqReady), .respValid(respValid),
    .respError(respError), .memSelN(memSelN), .latchEn(latchEn),
    .readN(readN), .writeN(writeN), .adOe(adOe), .strobe(strobe)
  );

  muxMemDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqByteEn(reqByteEn), .adIn(adIn),
    .adOut(adOut), .a16(a16), .byteHighN(byteHighN),
    .byteLowN(byteLowN), .respRdata(respRdata)
  );
endmodule

// File: rtl/muxMemChecker.sv
module muxMemChecker (
  input logic        clk,
  input logic        rstN,
  input logic        portEnable,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqAddr,
  input logic        respValid,
  input logic        respError,
  input logic [15:0] respRdata,
  input logic        adOe,
  input logic [3:0]  memSelN,
  input logic        latchEn,
  input logic        readN,
  input logic        writeN
);
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !portEnable) |=> (memSelN == 4'hF && respValid && respError));

  assert_miss_errors_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqAddr[31:28] > 4'd4) |=> (respError && respRdata == 16'h0));

  assert_latch_then_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |=> (!latchEn && memSelN == $past(memSelN) && (!readN || !writeN)));

  assert_read_releases_bus_R7: assert property (@(posedge clk) disable iff (!rstN)
    !readN |-> !adOe);

  assert_single_select_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memSelN));

  assert_no_dual_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(!readN && !writeN));

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memSelN != 4'hF) |-> !reqReady);
endmodule

bind muxMemBridge muxMemChecker uChecker (
  .clk(clk), .rstN(rstN), .portEnable(portEnable), .reqValid(reqValid),
  .reqReady(reqReady), .reqAddr(reqAddr), .respValid(respValid),
  .respError(respError), .respRdata(respRdata), .adOe(adOe),
  .memSelN(memSelN), .latchEn(latchEn), .readN(readN), .writeN(writeN)
);

// File: tb/tb_muxMemBridge.sv
`timescale 1ns/100ps
module tb_muxMemBridge;
  localparam int STROBE = 3;
  localparam real HALF = 2.5;

  logic clk = 1'b0, rstN = 1'b0, portEnable = 1'b1;
  logic [3:0] cfg8 = 4'b1010;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqReady;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqWdata = '0, respRdata, adOut, adIn = 16'hDEAD;
  logic [1:0] reqByteEn = '0;
  logic respValid, respError, adOe, a16, latchEn, readN, writeN, byteHighN, byteLowN;
  logic [3:0] memSelN;

  always #(HALF) clk = ~clk;

  muxMemBridge #(.STROBE_CLKS(STROBE)) dut (
    .clk(clk), .rstN(rstN), .portEnable(portEnable), .regionIs8Bit(cfg8),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .respValid(respValid), .respError(respError), .respRdata(respRdata),
    .adOut(adOut), .adOe(adOe), .adIn(adIn), .a16(a16), .memSelN(memSelN),
    .latchEn(latchEn), .readN(readN), .writeN(writeN),
    .byteHighN(byteHighN), .byteLowN(byteLowN)
  );

  int checks = 0, failures = 0, cyc = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] initByte(int key);
    return 8'((key * 37 + 11) ^ (key >> 8));
  endfunction

  // ---------------- pin-level device model ----------------
  typedef struct { logic [15:0] a; logic a16; logic [3:0] sel; } latchRec_t;
  latchRec_t latchLog[$];
  logic [7:0] devMem[int];
  logic [15:0] addrLat;
  logic a16Lat;
  int selIdx, strobeCnt, selCnt, violations = 0;

  function automatic logic [7:0] devGet(int k);
    return devMem.exists(k) ? devMem[k] : initByte(k);
  endfunction

  function automatic logic [15:0] devRead();
    int k;
    if (cfg8[selIdx]) begin
      k = (selIdx << 18) | int'({a16Lat, addrLat});
      return {8'hEE, devGet(k)};
    end
    k = (selIdx << 18) | int'({addrLat, 1'b0});
    return {devGet(k + 1), devGet(k)};
  endfunction

  always @(negedge clk) begin
    if (latchEn) begin
      latchLog.push_back('{adOut, a16, memSelN});
      addrLat = adOut;
      a16Lat  = a16;
      selIdx  = 0;
      for (int i = 0; i < 4; i++) if (!memSelN[i]) selIdx = i;
    end
    if (!writeN) begin
      if (cfg8[selIdx]) devMem[(selIdx << 18) | int'({a16Lat, addrLat})] = adOut[7:0];
      else begin
        if (!byteLowN)  devMem[(selIdx << 18) | int'({addrLat, 1'b0})] = adOut[7:0];
        if (!byteHighN) devMem[(selIdx << 18) | int'({addrLat, 1'b1})] = adOut[15:8];
      end
    end
    if (!readN || !writeN) strobeCnt++;
    if (memSelN != 4'hF) selCnt++;
    if (!readN && adOe) violations++;
    if (!readN && !writeN) violations++;
    if ($countones(~memSelN) > 1) violations++;
    adIn <= readN ? 16'hDEAD : devRead();
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic err; logic [15:0] data; int lat; int issue; string tag; } exp_t;
  exp_t sbq[$];
  logic [7:0] shadow[int];

  function automatic logic [7:0] shGet(int k);
    return shadow.exists(k) ? shadow[k] : initByte(k);
  endfunction

  function automatic int regionOf(logic [31:0] a);
    if (a[27:17] != 0) return -1;
    if (a[31:28] >= 4'd1 && a[31:28] <= 4'd4) return int'(a[31:28]) - 1;
    return -1;
  endfunction

  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (rstN && respValid) begin
      if (sbq.size() == 0) check(0, "R4", "unexpected response", 1, 0);
      else begin
        e = sbq.pop_front();
        check(respError == e.err, e.tag, "error flag", respError, e.err);
        check(respRdata == e.data, e.tag, "read data", respRdata, e.data);
        check(cyc - e.issue == e.lat, e.tag, "latency", cyc - e.issue, e.lat);
      end
    end
  end

  task automatic runReq(bit wr, logic [31:0] addr, logic [15:0] wd, logic [1:0] be, string tag);
    exp_t e;
    int r, k, n;
    bit w8;
    do begin @(negedge clk); #1; end while (!reqReady);
    latchLog.delete();
    strobeCnt = 0;
    selCnt = 0;
    r = regionOf(addr);
    e.tag = tag;
    e.err = (r < 0) || !portEnable;
    e.data = 16'h0;
    e.lat = 1;
    w8 = 1'b0;
    if (!e.err) begin
      w8 = cfg8[r];
      k = (r << 18) | int'({addr[16:1], 1'b0});
      e.lat = w8 ? 2 * (2 + STROBE) : 2 + STROBE;
      if (wr) begin
        if (w8 || be[0]) shadow[k]     = wd[7:0];
        if (w8 || be[1]) shadow[k + 1] = wd[15:8];
      end else e.data = {shGet(k + 1), shGet(k)};
    end
    e.issue = cyc;
    sbq.push_back(e);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd; reqByteEn = be;
    @(negedge clk); #1;
    check(!reqReady, "R10", "ready while busy", reqReady, 0);
    reqValid = 1'b0;
    while (sbq.size() != 0) begin @(negedge clk); #1; end
    if (e.err) begin
      check(selCnt == 0, tag, "select activity on unforwarded request", selCnt, 0);
    end else begin
      n = w8 ? 2 : 1;
      check(strobeCnt == n * STROBE, "R4", "strobe clocks", strobeCnt, n * STROBE);
      check(latchLog.size() == n, "R4", "address phases", latchLog.size(), n);
      for (int i = 0; i < n && i < latchLog.size(); i++) begin
        logic [16:0] expA;
        expA = w8 ? {addr[16:1], 1'(i)} : {1'b0, addr[16:1]};
        check(latchLog[i].a == expA[15:0], w8 ? "R8" : "R5", "bus address",
              latchLog[i].a, expA[15:0]);
        check(latchLog[i].a16 == expA[16], w8 ? "R8" : "R5", "extra address line",
              latchLog[i].a16, expA[16]);
        check(latchLog[i].sel == ~(4'b1 << r), "R3", "select", latchLog[i].sel, ~(4'b1 << r));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(memSelN == 4'hF, "R1", "selects in reset", memSelN, 4'hF);
    check(readN && writeN, "R1", "strobes in reset", {readN, writeN}, 2'b11);
    check(!latchEn && !respValid, "R1", "latch/valid in reset", {latchEn, respValid}, 0);
    check(reqReady, "R1", "ready in reset", reqReady, 1);
    rstN = 1'b1;

    // 16-bit window, full and partial writes (R5, R6, R7)
    runReq(0, 32'h1000_0010, 16'h0, 2'b00, "R7");
    runReq(1, 32'h1000_0010, 16'hBEEF, 2'b11, "R6");
    runReq(0, 32'h1000_0010, 16'h0, 2'b00, "R6");
    runReq(1, 32'h1000_0010, 16'h1234, 2'b01, "R6");
    runReq(0, 32'h1000_0010, 16'h0, 2'b00, "R6");
    runReq(1, 32'h1000_0010, 16'hAB00, 2'b10, "R6");
    runReq(0, 32'h1000_0010, 16'h0, 2'b00, "R6");
    runReq(0, 32'h3001_0002, 16'h0, 2'b00, "R5");
    runReq(1, 32'h3001_0002, 16'h5AA5, 2'b11, "R5");
    runReq(0, 32'h3001_0002, 16'h0, 2'b00, "R5");

    // 8-bit windows, two byte cycles (R8)
    runReq(0, 32'h2000_0104, 16'h0, 2'b00, "R8");
    runReq(1, 32'h2001_0200, 16'hC3A5, 2'b00, "R8");
    runReq(0, 32'h2001_0200, 16'h0, 2'b00, "R8");
    runReq(1, 32'h4001_FFFE, 16'h7E81, 2'b01, "R8");
    runReq(0, 32'h4001_FFFE, 16'h0, 2'b00, "R8");

    // unforwarded requests (R3, R2)
    runReq(0, 32'h5000_0000, 16'h0, 2'b00, "R3");
    runReq(0, 32'h0000_1000, 16'h0, 2'b00, "R3");
    runReq(1, 32'h1002_0000, 16'hFFFF, 2'b11, "R3");
    portEnable = 1'b0;
    runReq(0, 32'h1000_0010, 16'h0, 2'b00, "R2");
    runReq(1, 32'h2000_0000, 16'h1111, 2'b11, "R2");
    portEnable = 1'b1;
    runReq(0, 32'h1000_0010, 16'h0, 2'b00, "R2");

    check(violations == 0, "R9", "pin protocol violations (R7/R9)", violations, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(HALF * 2 * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule